// File: doc/BRIEF.md
# Three-Stage Programmable Master-Clock Prescaler

The block divides an incoming master clock through three chained dividers. Their product gives the internal converter clock, which runs at 256 times the audio sample rate. Each stage has its own two-bit selection input, so a single crystal frequency can serve several sample-rate families. Typical settings are:

- 12.288 MHz through /3 and /2 gives 2.048 MHz, for an 8 kHz rate.
- 24.576 MHz through /2 gives 12.288 MHz (48 kHz), and through /3 gives 8.192 MHz (32 kHz).
- 11.2896 MHz through /4 in the middle stage gives 2.8224 MHz (11.025 kHz).

The selections are registered on the master clock. Any change to any selection clears every stage counter on that same edge, so the new ratio starts from a clean phase. When all three stages pass through, the master clock itself is forwarded. Every other total ratio comes out of a register, with its duty cycle as close to half as whole master-clock periods allow. Odd ratios are built with a clock-enable counting scheme rather than dual-edge logic.

Top module: `presc_cascade`

## Requirements
- R1: Stage 1 selection codes are 2'b00 = /1, 2'b01 = /2 and 2'b10 = /3.
- R2: Stage 2 selection codes are 2'b00 = /1, 2'b01 = /2 and 2'b10 = /4.
- R3: Stage 3 selection codes are 2'b00 = /1, 2'b01 = /2 and 2'b10 = /5.
- R4: Code 2'b11 on any stage selects /1.
- R5: With selections held steady, the output period, measured in master-clock cycles from one rising edge to the next, equals the product of the three stage ratios.
- R6: For a total ratio N > 1, the output is high for ceil(N/2) master cycles and then low for floor(N/2) master cycles. It changes only just after a rising master edge.
- R7: When the total ratio is 1, the output is the master clock itself: high after a rising master edge and low after a falling one.
- R8: A rising edge that samples selections different from the previously registered ones clears all stage counters. The output is low for that one cycle. On the next edge a fresh high phase of the new ratio begins.
- R9: While reset is asserted, the registered selections read as all /1. The output therefore follows the master clock, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel1_i | input | 2 | Stage 1 ratio code |
| sel2_i | input | 2 | Stage 2 ratio code |
| sel3_i | input | 2 | Stage 3 ratio code |
| div_clk_o | output | 1 | Divided internal master clock |

## Verification
The hardest state to reach is a large total ratio built from stages that wrap at different moments. One example is /3 feeding /4 feeding /5, where the last stage advances only once every twelve master cycles. Checking that case fully needs a complete 60-cycle period after a clean restart. The stimulus walks all 64 code combinations, reserved codes included. It changes the selections mid-period so that every switch lands on an arbitrary phase. A behavioural phase model is compared against the output on every falling master edge, and the rise-to-rise period is counted for each combination.

// File: rtl/presc_pkg.sv
package presc_pkg;

   typedef enum logic [1:0] {
      SEL_DIV1 = 2'b00,
      SEL_DIV2 = 2'b01,
      SEL_ALT  = 2'b10,
      SEL_RSVD = 2'b11
   } sel_e;

   localparam int unsigned NUM_STAGES = 3;
   localparam int unsigned SEL_W      = 2;

endpackage

// File: rtl/presc_stage.sv
module presc_stage
   import presc_pkg::*;
#(
   parameter int unsigned ALT = 3,
   parameter int unsigned PW  = 6
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 clr_i,
   input  logic                 en_i,
   input  logic [SEL_W-1:0]     code_i,
   output logic [PW-1:0]        ratio_o,
   output logic [PW-1:0]        cnt_o,
   output logic                 tick_o
);

   localparam int unsigned RW = $clog2(ALT + 1);

   if (ALT < 3 || ALT > 15) begin : g_bad_alt
      $error("presc_stage: ALT must lie in 3..15");
   end
   if (PW < RW) begin : g_bad_pw
      $error("presc_stage: PW narrower than the stage counter");
   end

   logic [RW-1:0] ratio;
   logic [RW-1:0] cnt;
   logic          wrap;

   always_comb begin
      case (sel_e'(code_i))
         SEL_DIV2: ratio = RW'(2);
         SEL_ALT:  ratio = RW'(ALT);
         default:  ratio = RW'(1);
      endcase
   end

   assign wrap   = (cnt == ratio - RW'(1));
   assign tick_o = en_i & wrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (en_i) begin
         cnt <= wrap ? '0 : cnt + RW'(1);
      end
   end

   assign ratio_o = PW'(ratio);
   assign cnt_o   = PW'(cnt);

   // R5: a stage counter never reaches its ratio
   a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt < ratio);

   // R5: a wrap tick leaves the counter at zero
   a_r5_tick_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> (cnt == '0));

endmodule

// File: rtl/presc_duty.sv
module presc_duty
   import presc_pkg::*;
#(
   parameter int unsigned PW = 6
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            clr_i,
   input  logic [NUM_STAGES-1:0][PW-1:0]   ratio_i,
   input  logic [NUM_STAGES-1:0][PW-1:0]   cnt_i,
   output logic [PW-1:0]                   total_o,
   output logic                            div_q_o
);

   logic [PW-1:0] w1, w2, phase, half;
   logic          div_q;

   assign w1      = ratio_i[0];
   assign w2      = ratio_i[0] * ratio_i[1];
   assign total_o = w2 * ratio_i[2];
   assign phase   = cnt_i[0] + w1 * cnt_i[1] + w2 * cnt_i[2];
   assign half    = (total_o + PW'(1)) >> 1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= 1'b0;
      end else if (clr_i) begin
         div_q <= 1'b0;
      end else begin
         div_q <= (phase < half);
      end
   end

   assign div_q_o = div_q;

   // R8: a selection change clears every counter and drops the output
   a_r8_clear_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (phase == '0 && !div_q));

   // R6: a high phase always starts at combined phase zero
   a_r6_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(div_q) && total_o > PW'(1)) |-> (phase == PW'(1)));

   // R5: combined phase stays below the total ratio
   a_r5_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase < total_o);

endmodule

// File: rtl/presc_cascade.sv
module presc_cascade
   import presc_pkg::*;
#(
   parameter int unsigned STG1_ALT = 3,
   parameter int unsigned STG2_ALT = 4,
   parameter int unsigned STG3_ALT = 5
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] sel1_i,
   input  logic [1:0] sel2_i,
   input  logic [1:0] sel3_i,
   output logic       div_clk_o
);

   localparam int unsigned MAXN = STG1_ALT * STG2_ALT * STG3_ALT;
   localparam int unsigned PW   = $clog2(MAXN + 1);
   localparam int unsigned SW   = NUM_STAGES * SEL_W;

   function automatic int unsigned alt_of(input int unsigned idx);
      case (idx)
         0:       return STG1_ALT;
         1:       return STG2_ALT;
         default: return STG3_ALT;
      endcase
   endfunction

   logic [SW-1:0]                  sel_all, sel_q;
   logic                           chg;
   logic [NUM_STAGES:0]            en;
   logic [NUM_STAGES-1:0][PW-1:0]  ratio, cnt;
   logic [PW-1:0]                  total;
   logic                           div_q;

   assign sel_all = {sel3_i, sel2_i, sel1_i};
   assign chg     = (sel_all != sel_q);
   assign en[0]   = 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q <= '0;
      else         sel_q <= sel_all;
   end

   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
      presc_stage #(
         .ALT (alt_of(g)),
         .PW  (PW)
      ) u_stage (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clr_i   (chg),
         .en_i    (en[g]),
         .code_i  (sel_q[g*SEL_W +: SEL_W]),
         .ratio_o (ratio[g]),
         .cnt_o   (cnt[g]),
         .tick_o  (en[g+1])
      );
   end

   presc_duty #(.PW(PW)) u_duty (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (chg),
      .ratio_i (ratio),
      .cnt_i   (cnt),
      .total_o (total),
      .div_q_o (div_q)
   );

   assign div_clk_o = (total == PW'(1)) ? clk_i : div_q;

   // R9: the registered selections read as /1 right after reset
   a_r9_reset_sel: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> (sel_q == '0));

endmodule

// File: tb/sim_presc_cascade.sv
module sim_presc_cascade;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel1 = 2'b00, sel2 = 2'b00, sel3 = 2'b00;
   wire        div_clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   presc_cascade u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .sel1_i(sel1), .sel2_i(sel2), .sel3_i(sel3),
      .div_clk_o(div_clk)
   );

   function automatic int rat(input logic [1:0] c, input int alt);
      case (c)
         2'b01:   return 2;
         2'b10:   return alt;
         default: return 1;
      endcase
   endfunction

   function automatic int total_of(input logic [5:0] s);
      return rat(s[1:0], 3) * rat(s[3:2], 4) * rat(s[5:4], 5);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   // behavioural reference: phase counter and expected level
   logic [5:0] m_prev = '0;
   int  m_ph = 0;
   bit  m_exp = 0;
   bit  m_after_chg = 0;

   always @(posedge clk) begin
      logic [5:0] cur;
      int n;
      cur = {sel3, sel2, sel1};
      if (!rst_n) begin
         m_prev = '0; m_ph = 0; m_exp = 0; m_after_chg = 0;
      end else if (cur != m_prev) begin
         m_prev = cur; m_ph = 0; m_exp = 0; m_after_chg = 1;
      end else begin
         n = total_of(m_prev);
         m_exp = (m_ph < (n + 1) / 2);
         m_ph = (m_ph + 1) % n;
         m_after_chg = 0;
      end
   end

   always @(negedge clk) begin
      int n;
      bit e;
      if (rst_n && !done) begin
         n = total_of(m_prev);
         e = (n == 1) ? 1'b0 : m_exp;
         if (m_after_chg)  check(div_clk == e, "R8", int'(div_clk), int'(e));
         else if (n == 1)  check(div_clk == e, "R7", int'(div_clk), int'(e));
         else              check(div_clk == e, "R6", int'(div_clk), int'(e));
      end
   end

   task automatic measure(input logic [1:0] a, input logic [1:0] b,
                          input logic [1:0] c, input string tag);
      int n, cnt;
      bit last;
      @(negedge clk);
      sel1 = a; sel2 = b; sel3 = c;
      n = total_of({c, b, a});
      if (n == 1) begin
         @(posedge clk); @(posedge clk); #1;
         check(div_clk == 1'b1, tag, int'(div_clk), 1);
         @(negedge clk); #1;
         check(div_clk == 1'b0, tag, int'(div_clk), 0);
         return;
      end
      last = 1'b1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!last && div_clk) break;
         last = div_clk;
      end
      cnt = 0; last = 1'b1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         cnt++;
         if (!last && div_clk) break;
         last = div_clk;
      end
      check(cnt == n, tag, cnt, n);
   endtask

   initial begin
      // R9: output follows master clock during reset
      repeat (2) @(posedge clk);
      #1 check(div_clk == 1'b1, "R9", int'(div_clk), 1);
      @(negedge clk); #1 check(div_clk == 1'b0, "R9", int'(div_clk), 0);
      @(negedge clk); rst_n = 1'b1;

      measure(2'b01, 2'b00, 2'b00, "R1");
      measure(2'b10, 2'b00, 2'b00, "R1");
      measure(2'b00, 2'b01, 2'b00, "R2");
      measure(2'b00, 2'b10, 2'b00, "R2");
      measure(2'b00, 2'b00, 2'b01, "R3");
      measure(2'b00, 2'b00, 2'b10, "R3");
      measure(2'b11, 2'b10, 2'b00, "R4");
      measure(2'b10, 2'b11, 2'b11, "R4");
      measure(2'b00, 2'b00, 2'b00, "R7");

      for (int k = 0; k < 64; k++) begin
         logic [5:0] s;
         s = 6'(k);
         measure(s[1:0], s[3:2], s[5:4], "R5");
         // R8: switch mid-period to a different setting
         repeat (k % 7) @(negedge clk);
         sel1 = 2'b10; sel2 = 2'b01; sel3 = 2'(k % 3);
         repeat (5) @(negedge clk);
      end

      measure(2'b10, 2'b10, 2'b10, "R5");

      // R9: reset again mid-run
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1 check(div_clk == 1'b1, "R9", int'(div_clk), 1);
      @(negedge clk); #1 check(div_clk == 1'b0, "R9", int'(div_clk), 0);
      rst_n = 1'b1;
      measure(2'b10, 2'b01, 2'b00, "R1");

      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule